// File: doc/BRIEF.md
# Multi-Mode Serial Line Encoder

This block turns a serial bit stream into the level driven on a serial line. It runs with a x1 clock. A half-bit strobe arrives twice per bit cell. The first strobe of a cell marks the cell boundary, and the second marks mid-cell. A 2-bit field inside an 8-bit configuration word picks one of four encodings: plain level, level-toggle-on-zero, biphase mark or biphase space. A separate select bit overrides the field and gives Manchester output.

The data bit and the configuration are sampled at each cell boundary and then held for the whole cell. A setting written part-way through a cell therefore takes effect only at the next boundary. The encoder has no enable of its own. Whatever bit the transmitter presents while it is idle is encoded like any other data, so idle fill appears on the line in the chosen encoding.

Top module: `line_encoder`

## Requirements
- R1: After reset the line is high and the next half-bit strobe is treated as a cell boundary. From then on, strobes alternate between boundary and mid-cell.
- R2: The encoding is read from bits 6:5 of the configuration word: 00 plain level, 01 toggle-on-zero, 10 biphase mark, 11 biphase space. All other configuration bits have no effect.
- R3: In plain-level mode the line is set to the data bit at the boundary and holds through mid-cell.
- R4: In toggle-on-zero mode the line inverts at the boundary when the bit is 0, holds when the bit is 1, and holds at mid-cell.
- R5: In biphase-mark mode the line inverts at every boundary and inverts again at mid-cell only when the bit is 1.
- R6: In biphase-space mode the line inverts at every boundary and inverts again at mid-cell only when the bit is 0.
- R7: When the Manchester select is 1, the mode field is ignored. The line takes the bit value in the first half and its inverse in the second half: a 1 goes high to low, a 0 goes low to high.
- R8: The line changes only in the clock cycle after a strobe cycle. It holds when no strobe is present.
- R9: Changes to the configuration word or to the Manchester select between the boundary and mid-cell do not affect the current cell. They apply from the next boundary.
- R10: The data bit is sampled at the boundary only. A change at mid-cell does not alter the current cell.
- R11: Encoding runs on every strobe with no separate enable. A steady idle bit keeps producing its encoded pattern cell after cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | x1 clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_stb | input | 1 | Half-bit strobe, two per bit cell |
| data_bit | input | 1 | Serial data bit, sampled at the boundary |
| cfg_word | input | 8 | Configuration word; bits 6:5 hold the mode |
| manch_sel | input | 1 | 1 selects Manchester output |
| line_out | output | 1 | Encoded line level |

## Verification
A configuration update and a mid-cell transition can fall in the same cell. The bench provokes this by starting a biphase-mark cell with a 1. It then changes the mode field to plain level, raises the Manchester select and drops the data bit, all before the mid-cell strobe. The mid-cell level is judged correct only if it still follows the biphase-mark rule for the bit sampled at the boundary. The next cell must then show the newly chosen encoding.

// File: rtl/line_encoder_pkg.sv
package line_encoder_pkg;

  typedef enum logic [1:0] {
    ENC_LEVEL  = 2'b00,
    ENC_TOGGLE = 2'b01,
    ENC_MARK   = 2'b10,
    ENC_SPACE  = 2'b11
  } enc_mode_t;

  // Line level after the boundary strobe, from the level before it.
  function automatic logic f_boundary(enc_mode_t mode, logic manch, logic bit_v, logic cur);
    logic nxt;
    if (manch) begin
      nxt = bit_v;
    end else begin
      unique case (mode)
        ENC_LEVEL:  nxt = bit_v;
        ENC_TOGGLE: nxt = bit_v ? cur : ~cur;
        default:    nxt = ~cur;
      endcase
    end
    return nxt;
  endfunction

  // Line level after the mid-cell strobe, from the level before it.
  function automatic logic f_mid(enc_mode_t mode, logic manch, logic bit_v, logic cur);
    logic nxt;
    if (manch) begin
      nxt = ~bit_v;
    end else begin
      unique case (mode)
        ENC_MARK:  nxt = bit_v ? ~cur : cur;
        ENC_SPACE: nxt = bit_v ? cur : ~cur;
        default:   nxt = cur;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/enc_phase.sv
module enc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_stb,
  output logic at_bound,
  output logic at_mid
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= 1'b0;
    else if (half_stb) phase_q <= ~phase_q;
  end

  assign at_bound = half_stb & ~phase_q;
  assign at_mid   = half_stb &  phase_q;

  // R1: boundary and mid-cell strobes alternate
  p_alternate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_bound |=> (!half_stb || at_mid));
  p_mid_then_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_mid |=> (!half_stb || at_bound));

endmodule

// File: rtl/enc_cfg_latch.sv
module enc_cfg_latch
  import line_encoder_pkg::*;
#(
  parameter bit HAS_MANCH = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      at_bound,
  input  enc_mode_t mode_in,
  input  logic      manch_in,
  input  logic      bit_in,
  output enc_mode_t mode_q,
  output logic      manch_q,
  output logic      bit_q
);
  logic manch_eff;

  generate
    if (HAS_MANCH) begin : g_manch
      assign manch_eff = manch_in;
    end else begin : g_no_manch
      logic unused_manch;
      assign unused_manch = manch_in;
      assign manch_eff    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ENC_LEVEL;
      manch_q <= 1'b0;
      bit_q   <= 1'b1;
    end else if (at_bound) begin
      mode_q  <= mode_in;
      manch_q <= manch_eff;
      bit_q   <= bit_in;
    end
  end

  // R9, R10: cell settings only move at a boundary
  p_cell_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !at_bound |=> ($stable(mode_q) && $stable(manch_q)));
  p_bit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !at_bound |=> $stable(bit_q));

endmodule

// File: rtl/enc_line.sv
module enc_line
  import line_encoder_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      at_bound,
  input  logic      at_mid,
  input  enc_mode_t mode_in,
  input  logic      manch_in,
  input  logic      bit_in,
  input  enc_mode_t mode_q,
  input  logic      manch_q,
  input  logic      bit_q,
  output logic      line_q
);
  logic line_d;

  always_comb begin
    line_d = line_q;
    if (at_bound)    line_d = f_boundary(mode_in, manch_in, bit_in, line_q);
    else if (at_mid) line_d = f_mid(mode_q, manch_q, bit_q, line_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_d;
  end

  // R8: no strobe, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_bound || at_mid) |=> $stable(line_q));
  // R3: plain level follows the data at the boundary
  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bound && !manch_in && mode_in == ENC_LEVEL) |=> line_q == $past(bit_in));
  // R5, R6: biphase modes always invert at the boundary
  p_biphase_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bound && !manch_in && mode_in[1]) |=> line_q != $past(line_q));
  // R7: Manchester second half is the inverted bit
  p_manch_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && manch_q) |=> line_q == ~$past(bit_q));

endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import line_encoder_pkg::*;
#(
  parameter int CFG_W     = 8,
  parameter int MODE_LSB  = 5,
  parameter bit HAS_MANCH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_stb,
  input  logic             data_bit,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             manch_sel,
  output logic             line_out
);
  localparam int MODE_MSB = MODE_LSB + 1;

  logic      at_bound, at_mid;
  enc_mode_t mode_in, mode_q;
  logic      manch_live, manch_q, bit_q;
  logic      unused_cfg;

  assign mode_in    = enc_mode_t'(cfg_word[MODE_MSB:MODE_LSB]);
  assign unused_cfg = ^(cfg_word & ~({{(CFG_W-2){1'b0}}, 2'b11} << MODE_LSB));
  assign manch_live = HAS_MANCH ? manch_sel : 1'b0;

  enc_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_stb (half_stb),
    .at_bound (at_bound),
    .at_mid   (at_mid)
  );

  enc_cfg_latch #(.HAS_MANCH(HAS_MANCH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .at_bound (at_bound),
    .mode_in  (mode_in),
    .manch_in (manch_sel),
    .bit_in   (data_bit),
    .mode_q   (mode_q),
    .manch_q  (manch_q),
    .bit_q    (bit_q)
  );

  enc_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .at_bound (at_bound),
    .at_mid   (at_mid),
    .mode_in  (mode_in),
    .manch_in (manch_live),
    .bit_in   (data_bit),
    .mode_q   (mode_q),
    .manch_q  (manch_q),
    .bit_q    (bit_q),
    .line_q   (line_out)
  );

endmodule

// File: tb/test_line_encoder.sv
module test_line_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_stb = 1'b0;
  logic       data_bit = 1'b0;
  logic [7:0] cfg_word = 8'h00;
  logic       manch_sel = 1'b0;
  logic       line_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  line_encoder i_line_encoder (
    .clk(clk), .rst_n(rst_n), .half_stb(half_stb), .data_bit(data_bit),
    .cfg_word(cfg_word), .manch_sel(manch_sel), .line_out(line_out)
  );

  // {cfg, manch, data, first-half level, second-half level}; starts from line high
  localparam logic [11:0] VEC [14] = '{
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b1},  // R3
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R3
    {8'h20, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    {8'h20, 1'b0, 1'b0, 1'b1, 1'b1},  // R4
    {8'h20, 1'b0, 1'b0, 1'b0, 1'b0},  // R4
    {8'h40, 1'b0, 1'b1, 1'b1, 1'b0},  // R5
    {8'h40, 1'b0, 1'b0, 1'b1, 1'b1},  // R5
    {8'h60, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {8'h60, 1'b0, 1'b0, 1'b1, 1'b0},  // R6
    {8'h40, 1'b1, 1'b1, 1'b1, 1'b0},  // R7
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // R7
    {8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 FM-space with noise bits
    {8'h9F, 1'b0, 1'b1, 1'b1, 1'b1},  // R2 level with noise bits
    {8'h40, 1'b0, 1'b1, 1'b0, 1'b1}   // R2 FM-mark
  };

  task automatic check(input string req, input logic exp);
    total++;
    if (line_out !== exp) begin
      bad++;
      $display("FAIL %s: line_out=%b expected=%b", req, line_out, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) half_stb = 1'b1;
    @(negedge clk) half_stb = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset level", 1'b1);

    for (int i = 0; i < 14; i++) begin
      cfg_word  = VEC[i][11:4];
      manch_sel = VEC[i][3];
      data_bit  = VEC[i][2];
      strobe();
      check($sformatf("R2-table cell %0d first half", i), VEC[i][1]);
      strobe();
      check($sformatf("R2-table cell %0d second half", i), VEC[i][0]);
    end

    // R8: idle cycles without strobe hold the level (last level 1)
    repeat (6) @(negedge clk);
    check("R8 hold without strobe", 1'b1);

    // R1: reset mid-cell, first strobe after is a boundary
    cfg_word = 8'h00; manch_sel = 1'b0; data_bit = 1'b1;
    strobe();
    do_reset();
    check("R1 level after reset", 1'b1);
    data_bit = 1'b0;
    strobe();
    check("R1 boundary after reset", 1'b0);
    strobe();
    check("R1 mid after reset", 1'b0);

    // R9, R10: settings changed before mid-cell do not touch the cell
    do_reset();
    cfg_word = 8'h40; manch_sel = 1'b0; data_bit = 1'b1;
    strobe();
    check("R9 mark boundary", 1'b0);
    cfg_word = 8'h00; manch_sel = 1'b1; data_bit = 1'b0;
    strobe();
    check("R9 R10 mid keeps mark rule with bit 1", 1'b1);
    manch_sel = 1'b0;
    strobe();
    check("R9 new level mode applies", 1'b0);
    strobe();
    check("R9 new level mode second half", 1'b0);

    // R11: steady idle 1 in FM-space keeps toggling at each boundary
    cfg_word = 8'h60; data_bit = 1'b1;
    for (int k = 0; k < 4; k++) begin
      strobe();
      check("R11 idle boundary", (k % 2 == 0) ? 1'b1 : 1'b0);
      strobe();
      check("R11 idle mid", (k % 2 == 0) ? 1'b1 : 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule